// File: doc/BRIEF.md
# Audio Clock Generator and Frame Sync Monitor

This block runs from a master clock at 256 times the audio sample rate. When it is the clock master, it derives the serial bit clock (master clock divided by 4) and the frame clock (master clock divided by 256) from one shared counter. It also passes the master clock through to an output pin. When another device is the clock master, the generated outputs are held low. The block then watches the external frame clock, measuring the interval between its rising edges in master-clock cycles.

A frame interval outside 256 ± 10 cycles counts as a phase drift, and the block requests a resynchronisation with a one-cycle `sync_err` pulse. A frame clock that stops for 512 cycles raises the level flag `no_clk`. A change of the master/slave select or of the double-speed flag also restarts the divider and the monitor, and it requests a resync. The double-speed flag marks the 88.2/96 kHz rates. At those rates the master clock doubles with the sample rate, so the division ratios do not change.

Top module: `audclk_gen`

## Requirements
- R1: In master mode, bit and frame clocks come from one counter that is zero at reset and at restart and increments once per master clock. `bclk_out` equals counter bit 1, giving a period of 4. `fclk_out` equals counter bit 7, giving a period of 256, low for counts 0..127 and high for 128..255.
- R2: In slave mode, `bclk_out`, `fclk_out` and `mclk_out` are held low.
- R3: In master mode, `mclk_out` follows the master clock: it is high while `clk` is high.
- R4: While `rst` is high and on the cycle after it falls, `sync_err`, `no_clk`, `bclk_out` and `fclk_out` are low.
- R5: In slave mode, each rising edge of `ext_fclk` that has a reference is judged against the previous rising edge. An interval below 246 or above 266 master cycles produces a one-cycle `sync_err` pulse, three clock edges after the edge reaches the input.
- R6: The window bounds are inclusive: intervals of 246, 256 and 266 cycles produce no pulse.
- R7: The first `ext_fclk` rising edge after reset, after a mode change or after a no-clock condition has no reference and is never flagged.
- R8: In slave mode, `no_clk` sets once 512 master cycles pass without an `ext_fclk` rising edge. It clears on the next rising edge. `no_clk` and `sync_err` are never high together.
- R9: Any change of `master_sel` or `dbl_speed` produces a one-cycle `sync_err` pulse on the next cycle and restarts the divider count from zero.
- R10: The division ratios of R1 are the same with `dbl_speed` at 0 and at 1.
- R11: In master mode, `ext_fclk` is ignored: `sync_err` pulses only from R9, and `no_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 × sample rate |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | 1 = generate clocks, 0 = accept external clocks |
| dbl_speed | input | 1 | Double-rate operation flag |
| ext_fclk | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| fclk_out | output | 1 | Generated frame clock |
| mclk_out | output | 1 | Buffered master clock, low in slave mode |
| sync_err | output | 1 | One-cycle resync request |
| no_clk | output | 1 | Frame clock absent |

## Verification
A divider count that is off by even one shows up as a misplaced `bclk_out` edge within four cycles of the restart. The `fclk_out` edge then follows misplaced within 128 cycles. A wrong interval counter or window shows up as a missing or extra `sync_err` pulse at the first frame edge after the bad interval, so frame lengths of 245, 246, 266 and 267 cycles bracket both bounds. Stale reference state shows up as a false pulse on the first edge after a mode change or a stall. A wrong timeout shows up as `no_clk` not set 600 cycles into a stall, or not cleared shortly after the next edge.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    parameter int MCLK_PER_FS = 256;
    parameter int BCLK_DIV    = 4;
    parameter int PHASE_TOL   = 10;
    parameter int TIMEOUT     = 512;
    parameter int SYNC_STAGES = 2;

    typedef struct packed {
        logic master;
        logic dbl;
    } mode_t;

    function automatic logic interval_ok(int unsigned interval, int unsigned nominal,
                                         int unsigned tol);
        return (interval + tol >= nominal) && (interval <= nominal + tol);
    endfunction

endpackage

// File: rtl/audclk_sync.sv
module audclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/audclk_divider.sv
module audclk_divider #(
    parameter int RATIO     = 256,
    parameter int BCLK_DIV  = 4,
    localparam int CNT_W    = $clog2(RATIO),
    localparam int BCLK_BIT = $clog2(BCLK_DIV) - 1,
    localparam int FCLK_BIT = CNT_W - 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic enable,
    output logic bclk,
    output logic fclk
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || restart) count_q <= '0;
        else                count_q <= count_q + 1'b1;
    end

    assign bclk = enable & count_q[BCLK_BIT];
    assign fclk = enable & count_q[FCLK_BIT];
endmodule

// File: rtl/audclk_frame_monitor.sv
module audclk_frame_monitor
    import audclk_pkg::*;
#(
    parameter int NOMINAL  = 256,
    parameter int TOL      = 10,
    parameter int TIMEOUT  = 512,
    localparam int GAP_W   = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    input  logic fclk_s,
    output logic phase_err,
    output logic no_clk
);
    logic             prev_q;
    logic             have_ref_q;
    logic [GAP_W-1:0] gap_q;
    logic             rise;
    logic             in_win;
    logic             timed_out;

    assign rise      = fclk_s & ~prev_q;
    assign in_win    = interval_ok(32'(gap_q), NOMINAL, TOL);
    assign timed_out = (gap_q == GAP_W'(TIMEOUT));

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            prev_q     <= fclk_s;
            have_ref_q <= 1'b0;
            gap_q      <= '0;
            phase_err  <= 1'b0;
            no_clk     <= 1'b0;
        end else begin
            prev_q    <= fclk_s;
            phase_err <= 1'b0;
            if (rise) begin
                gap_q      <= GAP_W'(1);
                have_ref_q <= 1'b1;
                no_clk     <= 1'b0;
                if (have_ref_q && !in_win) phase_err <= 1'b1;
            end else if (!timed_out) begin
                gap_q <= gap_q + 1'b1;
            end else begin
                no_clk     <= 1'b1;
                have_ref_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int RATIO     = MCLK_PER_FS,
    parameter int BDIV      = BCLK_DIV,
    parameter int TOL       = PHASE_TOL,
    parameter int NOCLK_LIM = TIMEOUT,
    parameter int STAGES    = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic master_sel,
    input  logic dbl_speed,
    input  logic ext_fclk,
    output logic bclk_out,
    output logic fclk_out,
    output logic mclk_out,
    output logic sync_err,
    output logic no_clk
);
    mode_t mode_in;
    mode_t mode_q;
    logic  mode_chg;
    logic  chg_q;
    logic  fclk_s;
    logic  mon_err;

    assign mode_in  = '{master: master_sel, dbl: dbl_speed};
    assign mode_chg = (mode_in != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_in;
            chg_q  <= 1'b0;
        end else begin
            mode_q <= mode_in;
            chg_q  <= mode_chg;
        end
    end

    audclk_divider #(.RATIO(RATIO), .BCLK_DIV(BDIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (mode_chg),
        .enable  (mode_q.master),
        .bclk    (bclk_out),
        .fclk    (fclk_out)
    );

    audclk_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_fclk),
        .q   (fclk_s)
    );

    audclk_frame_monitor #(.NOMINAL(RATIO), .TOL(TOL), .TIMEOUT(NOCLK_LIM)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .enable    (!mode_q.master),
        .restart   (mode_chg),
        .fclk_s    (fclk_s),
        .phase_err (mon_err),
        .no_clk    (no_clk)
    );

    assign mclk_out = clk & mode_q.master;
    assign sync_err = chg_q | mon_err;
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic master_sel,
    input logic dbl_speed,
    input logic bclk_out,
    input logic fclk_out,
    input logic sync_err,
    input logic no_clk
);
    // R1
    fclk_rise_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fclk_out) |-> $fell(bclk_out));

    // R2
    slave_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_sel && !$past(master_sel)) |-> (!bclk_out && !fclk_out));

    // R9
    mode_change_resync_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel != $past(master_sel) || dbl_speed != $past(dbl_speed)) |=> sync_err);

    // R8
    noclk_excludes_err_chk: assert property (@(posedge clk) disable iff (rst)
        !(no_clk && sync_err));

    // R11
    noclk_slave_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(no_clk) |-> !$past(master_sel));

    // R11
    master_no_noclk_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && $past(master_sel)) |-> !no_clk);
endmodule

bind audclk_gen audclk_gen_chk u_chk (.*);

// File: tb/audclk_gen_test.sv
module audclk_gen_test;
    logic clk = 1'b0;
    logic rst, master_sel, dbl_speed, ext_fclk;
    logic bclk_out, fclk_out, mclk_out, sync_err, no_clk;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    audclk_gen uut (
        .clk(clk), .rst(rst), .master_sel(master_sel), .dbl_speed(dbl_speed),
        .ext_fclk(ext_fclk), .bclk_out(bclk_out), .fclk_out(fclk_out),
        .mclk_out(mclk_out), .sync_err(sync_err), .no_clk(no_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // expected divider count at the next negedge is start_v, then increments
    task automatic check_divider(input int start_v, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int v;
            @(negedge clk);
            v = (start_v + i) % 256;
            chk(bclk_out == ((v >> 1) & 1), req, bclk_out, (v >> 1) & 1);
            chk(fclk_out == ((v >> 7) & 1), req, fclk_out, (v >> 7) & 1);
        end
    endtask

    // one frame: rising edge, high half, low half; exp is the verdict for this edge
    task automatic frame(input int len, input bit exp);
        @(negedge clk);
        ext_fclk = 1'b1;
        exp_q.push_back(exp);
        repeat (len / 2 - 1) @(negedge clk);
        ext_fclk = 1'b0;
        repeat (len - len / 2) @(negedge clk);
    endtask

    // scoreboard monitor: one verdict per ext_fclk rising edge (R5, R6, R7, R11)
    initial begin
        forever begin
            bit seen;
            bit exp;
            @(posedge ext_fclk);
            seen = 1'b0;
            repeat (5) begin
                @(negedge clk);
                seen |= sync_err;
            end
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            chk(seen == exp, "R5/R6/R7/R11 frame verdict", seen, exp);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; master_sel = 1'b1; dbl_speed = 1'b0; ext_fclk = 1'b0;
        repeat (4) @(negedge clk);
        // R4 reset state
        chk(!bclk_out && !fclk_out, "R4 clocks low in reset", bclk_out | fclk_out, 0);
        chk(!sync_err && !no_clk, "R4 flags low in reset", sync_err | no_clk, 0);
        rst = 1'b0;
        check_divider(1, 1, "R4 first cycle after reset");
        chk(!sync_err && !no_clk, "R4 flags after reset", sync_err | no_clk, 0);
        // R1 divider in normal speed
        check_divider(2, 600, "R1 divider");
        // R3 buffered master clock
        @(posedge clk); #2;
        chk(mclk_out == 1'b1, "R3 mclk_out high phase", mclk_out, 1);
        // R11 external frame clock ignored in master mode
        frame(300, 1'b0);
        frame(200, 1'b0);
        repeat (700) @(negedge clk);
        chk(!no_clk, "R11 no_clk in master mode", no_clk, 0);
        // R9 / R10 double-speed toggle restarts the divider
        @(negedge clk); dbl_speed = 1'b1;
        @(negedge clk);
        chk(sync_err == 1'b1, "R9 resync on speed change", sync_err, 1);
        chk(!bclk_out && !fclk_out, "R9 divider restarted", bclk_out | fclk_out, 0);
        @(negedge clk);
        chk(sync_err == 1'b0, "R9 resync pulse one cycle", sync_err, 0);
        check_divider(2, 520, "R10 divider at double speed");
        // R2 slave mode
        @(negedge clk); master_sel = 1'b0;
        @(negedge clk);
        chk(sync_err == 1'b1, "R9 resync on slave select", sync_err, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!bclk_out && !fclk_out, "R2 generated clocks low", bclk_out | fclk_out, 0);
        end
        @(posedge clk); #2;
        chk(mclk_out == 1'b0, "R2 mclk_out low", mclk_out, 0);
        // R5 R6 R7 slave frame sequence
        frame(256, 1'b0);   // R7 first edge, no reference
        frame(266, 1'b0);   // after 256
        frame(267, 1'b0);   // after 266: R6 upper bound inclusive
        frame(246, 1'b1);   // after 267: R5 too long
        frame(245, 1'b0);   // after 246: R6 lower bound inclusive
        frame(256, 1'b1);   // after 245: R5 too short
        frame(700, 1'b0);   // after 256: ok, then stall
        // R8 no-clock after the stall
        chk(no_clk == 1'b1, "R8 no_clk after stall", no_clk, 1);
        frame(256, 1'b0);   // R7 no reference after timeout
        chk(no_clk == 1'b0, "R8 no_clk cleared by edge", no_clk, 0);
        frame(256, 1'b0);
        repeat (10) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule